// File: doc/BRIEF.md
# Vector compare-immediate engine with fail-first length truncation

The engine walks a vector of integer register elements one per clock and compares each element, as a signed number, against a signed immediate. Every comparison yields a 4-bit condition field written to a condition-field store. After each field is produced, a selectable bit of it is checked against a required value. The first element whose check fails ends the loop. The vector length is then cut at that point, either keeping the failing element (inclusive) or dropping it (exclusive). The cut may reach zero.

Either operand may be a vector or a scalar. A vector source reads consecutive registers from its base index. A scalar source rereads the base register for every element. In the same way, a vector destination writes consecutive condition fields, while a scalar destination overwrites one field. Indices wrap modulo the store size. A command is given as a one-cycle `start` with its operands. All operands are captured at that edge, and `start` is ignored while a command is running. The engine reports the final length and pulses `done`.

Top module: `vec_cmp_trunc`

## Requirements
- R1: After reset `vl_out` is 0, `done` is 0 and `cf_we` is 0.
- R2: Each written condition field has bit 3 = source < immediate, bit 2 = source > immediate, and bit 1 = source == immediate, all signed. Bit 0 is a copy of `so_in`. Exactly one of bits 3..1 is set.
- R3: Element i (counted from 0) is written in the (i+1)-th cycle after the edge that samples `start`, one element per cycle. `vl_out` equals the commanded length while elements are being written.
- R4: The read address for element i is `src_base + i` modulo the register count when `src_vec` is 1. It is `src_base` for every element when `src_vec` is 0.
- R5: The write address for element i is `dst_base + i` modulo the field count when `dst_vec` is 1. It is `dst_base` for every element when `dst_vec` is 0.
- R6: `test_sel` picks the checked bit: 0 = LT (bit 3), 1 = GT (bit 2), 2 = EQ (bit 1), 3 = SO (bit 0). An element fails when that bit differs from `test_sense`. No field is written after the failing one.
- R7: On a failure at element i, `vl_out` becomes i+1 when `incl_mode` is 1 and i when it is 0. A failure at element 0 in exclusive mode gives 0.
- R8: If no element fails, `vl_out` keeps the commanded length. `done` rises in the cycle after the last write.
- R9: A commanded length of 0 produces no writes, and `done` is 1 in the cycle after `start` is sampled, with `vl_out` = 0.
- R10: `start` and operand changes while a command runs have no effect on addresses, fields or the final length.
- R11: `done` is high for exactly one cycle. `vl_out` then holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle |
| src_base | input | $clog2(NREG) | First source register index |
| dst_base | input | $clog2(NCF) | First destination condition-field index |
| src_vec | input | 1 | Source is a vector (1) or a scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or a scalar (0) |
| imm | input | XLEN | Signed immediate |
| vl_in | input | VLW | Commanded vector length |
| test_sel | input | 2 | Selects the condition bit to test |
| test_sense | input | 1 | Required value of the tested bit |
| incl_mode | input | 1 | 1 keeps the failing element, 0 drops it |
| so_in | input | 1 | Sticky overflow copied into bit 0 |
| rf_raddr | output | $clog2(NREG) | Register read address |
| rf_rdata | input | XLEN | Register read data, same cycle |
| cf_we | output | 1 | Condition-field write enable |
| cf_waddr | output | $clog2(NCF) | Condition-field write address |
| cf_wdata | output | 4 | Condition field {LT, GT, EQ, SO} |
| vl_out | output | VLW | Resulting vector length |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with XLEN=8, NREG=8, NCF=8 and VLW=4. Lengths of up to 15 therefore run past both 8-entry stores, so base indices near the top wrap around within a single command. An 8-bit element width makes random data often equal the immediate and often cross the sign boundary, which exercises the EQ and signed LT/GT paths. Together with random test selection, this yields early, late and absent failures in both truncation modes.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    // condition field, MSB first: less, greater, equal, sticky overflow
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    typedef enum logic [1:0] {
        PICK_LT = 2'd0,
        PICK_GT = 2'd1,
        PICK_EQ = 2'd2,
        PICK_SO = 2'd3
    } pick_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/vcmp_compare.sv
module vcmp_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]      elem,
    input  logic [XLEN-1:0]      imm,
    input  logic                 so_in,
    output vcmp_pkg::cond_t      cond
);
    always_comb begin
        cond.lt = $signed(elem) <  $signed(imm);
        cond.gt = $signed(elem) >  $signed(imm);
        cond.eq = elem == imm;
        cond.so = so_in;
    end
endmodule

// File: rtl/vcmp_test.sv
module vcmp_test (
    input  vcmp_pkg::cond_t cond,
    input  logic [1:0]      sel,
    input  logic            sense,
    output logic            fail
);
    import vcmp_pkg::*;
    logic picked;

    always_comb begin
        case (pick_e'(sel))
            PICK_LT: picked = cond.lt;
            PICK_GT: picked = cond.gt;
            PICK_EQ: picked = cond.eq;
            default: picked = cond.so;
        endcase
        fail = picked != sense;
    end
endmodule

// File: rtl/vcmp_step.sv
module vcmp_step #(
    parameter int W = 5
) (
    input  logic [W-1:0] cur,
    input  logic         advance,
    output logic [W-1:0] nxt
);
    // wraps modulo 2**W
    assign nxt = advance ? cur + W'(1) : cur;
endmodule

// File: rtl/vec_cmp_trunc.sv
module vec_cmp_trunc #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int NCF  = 8,
    parameter int VLW  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(NREG)-1:0]  src_base,
    input  logic [$clog2(NCF)-1:0]   dst_base,
    input  logic                     src_vec,
    input  logic                     dst_vec,
    input  logic [XLEN-1:0]          imm,
    input  logic [VLW-1:0]           vl_in,
    input  logic [1:0]               test_sel,
    input  logic                     test_sense,
    input  logic                     incl_mode,
    input  logic                     so_in,
    output logic [$clog2(NREG)-1:0]  rf_raddr,
    input  logic [XLEN-1:0]          rf_rdata,
    output logic                     cf_we,
    output logic [$clog2(NCF)-1:0]   cf_waddr,
    output logic [3:0]               cf_wdata,
    output logic [VLW-1:0]           vl_out,
    output logic                     done
);
    import vcmp_pkg::*;

    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(NCF);

    typedef struct packed {
        phase_e          phase;
        logic [RW-1:0]   sidx;
        logic [CW-1:0]   didx;
        logic [VLW-1:0]  elem;
        logic [VLW-1:0]  lim;
        logic [VLW-1:0]  vl;
        logic            src_vec;
        logic            dst_vec;
        logic [XLEN-1:0] imm;
        logic [1:0]      sel;
        logic            sense;
        logic            incl;
        logic            done;
    } regs_t;

    regs_t r_d, r_q;
    cond_t cond;
    logic  fail;
    logic  last;
    logic [RW-1:0] sidx_nxt;
    logic [CW-1:0] didx_nxt;

    vcmp_compare #(.XLEN(XLEN)) u_cmp (
        .elem  (rf_rdata),
        .imm   (r_q.imm),
        .so_in (so_in),
        .cond  (cond)
    );

    vcmp_test u_test (
        .cond  (cond),
        .sel   (r_q.sel),
        .sense (r_q.sense),
        .fail  (fail)
    );

    vcmp_step #(.W(RW)) u_src_step (
        .cur     (r_q.sidx),
        .advance (r_q.src_vec),
        .nxt     (sidx_nxt)
    );

    vcmp_step #(.W(CW)) u_dst_step (
        .cur     (r_q.didx),
        .advance (r_q.dst_vec),
        .nxt     (didx_nxt)
    );

    assign last = r_q.elem == r_q.lim - VLW'(1);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.phase)
            ST_IDLE: begin
                if (start) begin
                    r_d.sidx    = src_base;
                    r_d.didx    = dst_base;
                    r_d.elem    = '0;
                    r_d.lim     = vl_in;
                    r_d.vl      = vl_in;
                    r_d.src_vec = src_vec;
                    r_d.dst_vec = dst_vec;
                    r_d.imm     = imm;
                    r_d.sel     = test_sel;
                    r_d.sense   = test_sense;
                    r_d.incl    = incl_mode;
                    if (vl_in == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.phase = ST_RUN;
                    end
                end
            end
            default: begin
                if (fail) begin
                    r_d.vl    = r_q.incl ? r_q.elem + VLW'(1) : r_q.elem;
                    r_d.done  = 1'b1;
                    r_d.phase = ST_IDLE;
                end else if (last) begin
                    r_d.done  = 1'b1;
                    r_d.phase = ST_IDLE;
                end else begin
                    r_d.elem = r_q.elem + VLW'(1);
                    r_d.sidx = sidx_nxt;
                    r_d.didx = didx_nxt;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rf_raddr = r_q.sidx;
    assign cf_waddr = r_q.didx;
    assign cf_we    = r_q.phase == ST_RUN;
    assign cf_wdata = cond;
    assign vl_out   = r_q.vl;
    assign done     = r_q.done;

endmodule

// File: rtl/vcmp_chk.sv
module vcmp_chk #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int NCF  = 8,
    parameter int VLW  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cf_we,
    input logic [$clog2(NREG)-1:0] rf_raddr,
    input logic [$clog2(NCF)-1:0]  cf_waddr,
    input logic [3:0]              cf_wdata,
    input logic [VLW-1:0]          vl_out,
    input logic                    done,
    input logic                    src_vec_q,
    input logic                    dst_vec_q,
    input logic [VLW-1:0]          lim_q
);
    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(NCF);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_we |-> $countones(cf_wdata[3:1]) == 1);

    // R6
    quiet_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cf_we);

    // R4
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_we && $past(cf_we) && !src_vec_q |-> rf_raddr == $past(rf_raddr));

    // R4
    src_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_we && $past(cf_we) && src_vec_q |-> rf_raddr == RW'($past(rf_raddr) + 1'b1));

    // R5
    dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_we && $past(cf_we) && !dst_vec_q |-> cf_waddr == $past(cf_waddr));

    // R5
    dst_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_we && $past(cf_we) && dst_vec_q |-> cf_waddr == CW'($past(cf_waddr) + 1'b1));

    // R7
    no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> vl_out <= lim_q);

endmodule

bind vec_cmp_trunc vcmp_chk #(
    .XLEN (XLEN),
    .NREG (NREG),
    .NCF  (NCF),
    .VLW  (VLW)
) u_vcmp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cf_we     (cf_we),
    .rf_raddr  (rf_raddr),
    .cf_waddr  (cf_waddr),
    .cf_wdata  (cf_wdata),
    .vl_out    (vl_out),
    .done      (done),
    .src_vec_q (r_q.src_vec),
    .dst_vec_q (r_q.dst_vec),
    .lim_q     (r_q.lim)
);

// File: tb/test_vec_cmp_trunc.sv
module test_vec_cmp_trunc;
    localparam int XLEN = 8;
    localparam int NREG = 8;
    localparam int NCF  = 8;
    localparam int VLW  = 4;
    localparam int RW   = $clog2(NREG);
    localparam int CW   = $clog2(NCF);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [RW-1:0]   src_base = '0;
    logic [CW-1:0]   dst_base = '0;
    logic            src_vec = 1'b0;
    logic            dst_vec = 1'b0;
    logic [XLEN-1:0] imm = '0;
    logic [VLW-1:0]  vl_in = '0;
    logic [1:0]      test_sel = '0;
    logic            test_sense = 1'b0;
    logic            incl_mode = 1'b0;
    logic            so_in = 1'b0;
    logic [RW-1:0]   rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic            cf_we;
    logic [CW-1:0]   cf_waddr;
    logic [3:0]      cf_wdata;
    logic [VLW-1:0]  vl_out;
    logic            done;

    logic [XLEN-1:0] rf_mem [NREG];
    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    assign rf_rdata = rf_mem[rf_raddr];

    always #5 clk = ~clk;

    vec_cmp_trunc #(.XLEN(XLEN), .NREG(NREG), .NCF(NCF), .VLW(VLW)) i_vec_cmp_trunc (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec), .imm(imm), .vl_in(vl_in), .test_sel(test_sel),
        .test_sense(test_sense), .incl_mode(incl_mode), .so_in(so_in), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .cf_we(cf_we), .cf_waddr(cf_waddr), .cf_wdata(cf_wdata),
        .vl_out(vl_out), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model of one command, compared every cycle
    task automatic run_op(input int sb, input int db, input bit sv, input bit dv,
                          input int im, input int vl, input int sel, input bit sense,
                          input bit incl, input bit so, input int poke);
        int  exp_vl = vl;
        bit  failed = 1'b0;
        int  m = im;
        string fin;
        src_base = RW'(sb); dst_base = CW'(db); src_vec = sv; dst_vec = dv;
        imm = XLEN'(im); vl_in = VLW'(vl); test_sel = 2'(sel); test_sense = sense;
        incl_mode = incl; so_in = so; start = 1'b1;
        if (m >= 128) m -= 256;
        @(negedge clk);
        start = 1'b0;
        if (vl == 0) begin
            chk("R9 done", int'(done), 1);
            chk("R9 we", int'(cf_we), 0);
            chk("R9 vl", int'(vl_out), 0);
        end else begin
            for (int i = 0; i < vl && !failed; i++) begin
                int ra = sv ? (sb + i) % NREG : sb;
                int da = dv ? (db + i) % NCF : db;
                int v  = int'(rf_mem[ra]);
                bit lt, gt, eq, pick;
                if (v >= 128) v -= 256;
                lt = v < m; gt = v > m; eq = v == m;
                case (sel)
                    0: pick = lt;
                    1: pick = gt;
                    2: pick = eq;
                    default: pick = so;
                endcase
                chk("R3 we", int'(cf_we), 1);
                chk("R3 vl", int'(vl_out), vl);
                chk("R11 done low", int'(done), 0);
                chk("R4 raddr", int'(rf_raddr), ra);
                chk("R5 waddr", int'(cf_waddr), da);
                chk("R2 field", int'(cf_wdata), {lt, gt, eq, so});
                if (pick != sense) begin
                    failed = 1'b1;
                    exp_vl = incl ? i + 1 : i;
                end
                if (poke == i) begin
                    start = 1'b1;
                    vl_in = VLW'(~vl);
                    src_base = RW'(sb + 3);
                    dst_base = CW'(db + 5);
                    src_vec = ~sv;
                    imm = XLEN'(im + 1);
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
            start = 1'b0;
            if (poke >= 0)   fin = "R10 vl";
            else if (failed) fin = "R7 vl";
            else             fin = "R8 vl";
            chk("R8 done", int'(done), 1);
            chk("R6 no write", int'(cf_we), 0);
            chk(fin, int'(vl_out), exp_vl);
        end
        @(negedge clk);
        chk("R11 pulse", int'(done), 0);
        chk("R6 idle", int'(cf_we), 0);
        chk("R11 hold", int'(vl_out), exp_vl);
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) rf_mem[k] = XLEN'(k - 4);
        repeat (3) @(negedge clk);
        chk("R1 vl", int'(vl_out), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 we", int'(cf_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // vector/vector, never fails on SO test
        run_op(0, 0, 1, 1, 0, 5, 3, 1'b1, 1'b0, 1'b1, -1);
        // signed LT required, element 4 (value 0) fails, inclusive
        run_op(0, 2, 1, 0, 0, 7, 0, 1'b1, 1'b1, 1'b0, -1);
        // GT required, element 0 fails, exclusive -> zero length
        run_op(0, 1, 1, 1, 0, 6, 1, 1'b1, 1'b0, 1'b0, -1);
        // zero commanded length
        run_op(3, 3, 1, 1, 0, 0, 0, 1'b1, 1'b0, 1'b0, -1);
        // wrap both stores
        run_op(6, 5, 1, 1, 0, 12, 3, 1'b0, 1'b1, 1'b0, -1);
        // scalar source, vector destination, EQ must be 0
        run_op(2, 0, 0, 1, 0, 6, 2, 1'b0, 1'b0, 1'b0, -1);
        // vector source, scalar destination, EQ to 1 at element 5, exclusive
        run_op(0, 4, 1, 0, 1, 9, 2, 1'b0, 1'b0, 1'b1, -1);
        // negative immediate vs 8'h80
        rf_mem[7] = 8'h80;
        run_op(7, 0, 0, 0, 8'hFF, 3, 0, 1'b0, 1'b1, 1'b0, -1);
        // start and operand changes mid-run
        run_op(1, 1, 1, 1, 0, 6, 3, 1'b0, 1'b0, 1'b0, 2);
        for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < NREG; k++) rf_mem[k] = XLEN'($urandom_range(0, 7) + 8'hFC);
            run_op(int'($urandom_range(0, NREG - 1)), int'($urandom_range(0, NCF - 1)),
                   1'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
                   1'($urandom), 1'($urandom), 1'($urandom),
                   (n % 7 == 0) ? 1 : -1);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule